// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is a master-only SPI controller that sits on an 8-bit special-function-register bus. Software queues outgoing bytes in a transmit holding register and collects incoming bytes from a separate receive holding register. A single 8-bit shift register moves each byte out on `mosi` while it captures the reply from `miso`. The block generates the serial clock itself from the peripheral clock, and it drives the active-low select.

Each direction has one byte of buffering in front of the shifter. While the shifter is busy, software can load the next outgoing byte and read the previous incoming byte, so a stream of bytes goes out with no idle clock between them. Full and empty conditions are shown in a status register. Each condition can be enabled separately to raise an interrupt line.

Register map (offsets from `BASE`, default D0h): control at +0 (bit 0 enables starting transfers), interrupt enable at +1, divider select at +2 (bits 2:0), status at +3, transmit data at +4 (D4h), and receive data at +5 (D5h).

Top module: `spi_master_dbuf`

## Requirements
- R1: After reset, `ss_n` is 1, `sclk` is 0, `mosi` is 0, `irq` is 0, and the status register reads 00h.
- R2: The transmit register at D4h is write-only and reads 00h. The receive register at D5h is read-only, and a write to it leaves the received byte unchanged.
- R3: A write to D4h sets status bit 0 (transmit full). The bit clears on the cycle the byte is loaded into the shifter.
- R4: Divider select 0..6 gives a half-period of 1, 4, 8, 16, 32, 64 or 128 clock cycles on `sclk`. Select 7 behaves like 6.
- R5: `sclk` idles low. Bits go out most significant first. `mosi` changes only when `sclk` falls or a byte is loaded. `miso` is sampled when `sclk` rises.
- R6: `ss_n` goes low on the cycle a byte is loaded. It returns high only after the falling `sclk` edge of the last bit when no further byte is queued.
- R7: When a byte completes, it is placed at D5h and status bit 1 (receive full) is set. A read of D5h clears bit 1.
- R8: If a byte completes while bit 1 is still set and D5h is not being read, status bit 2 (overrun) is set and the held byte is kept. Writing a 1 to status bit 2 clears it.
- R9: `irq` is the OR of: (interrupt-enable bit 0 AND NOT transmit full), (bit 1 AND receive full), and (bit 2 AND overrun).
- R10: When control bit 0 is 0, no new byte starts. A queued byte waits with transmit full set until the bit is set again.
- R11: A byte queued before the current one ends starts on the same clock as that end, with no extra `sclk` period. Status bit 3 shows a transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low select |
| irq | output | 1 | Interrupt request |

## Verification
A wrong phase counter or bit counter shows within one `sclk` half-period: `sclk`, `mosi` or `ss_n` departs from a timing model that the bench computes from the bit position and the divide ratio. A lost or corrupted holding-register flag shows up on `irq` as early as the next clock when its enable is set. It also shows at the next status read, or at the next byte boundary, where a gap or a stray select release appears. A wrong receive byte or overrun decision is visible only when D5h or the status register is read. The bench reads both after every scenario.

// File: rtl/spi_master_dbuf.sv
module spi_master_dbuf #(
  parameter logic [7:0] BASE = 8'hD0
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso,
  output logic       ss_n,
  output logic       irq
);
  localparam logic [7:0] A_CTRL = BASE;
  localparam logic [7:0] A_IE   = BASE + 8'd1;
  localparam logic [7:0] A_DIV  = BASE + 8'd2;
  localparam logic [7:0] A_STAT = BASE + 8'd3;
  localparam logic [7:0] A_TX   = BASE + 8'd4;
  localparam logic [7:0] A_RX   = BASE + 8'd5;

  logic       en_r;
  logic [2:0] ie_r, div_sel;
  logic [7:0] tx_hold, rx_hold, shreg, cnt, half;
  logic       tx_full, rx_full, ovr, busy, sclk_r, rx_bit;
  logic [2:0] bitcnt;

  wire wr_tx = wr_en && addr == A_TX;
  wire rd_rx = rd_en && addr == A_RX;
  wire tick  = cnt >= half - 8'd1;
  wire rise  = busy && tick && !sclk_r;
  wire fall  = busy && tick && sclk_r;
  wire done  = fall && bitcnt == 3'd7;
  wire start = (!busy || done) && en_r && tx_full;
  wire [7:0] rx_byte = {shreg[6:0], rx_bit};

  always_comb
    case (div_sel)
      3'd0:    half = 8'd1;
      3'd1:    half = 8'd4;
      3'd2:    half = 8'd8;
      3'd3:    half = 8'd16;
      3'd4:    half = 8'd32;
      3'd5:    half = 8'd64;
      default: half = 8'd128;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_r <= 1'b0; ie_r <= '0; div_sel <= '0;
    end else if (wr_en) begin
      if (addr == A_CTRL) en_r    <= wdata[0];
      if (addr == A_IE)   ie_r    <= wdata[2:0];
      if (addr == A_DIV)  div_sel <= wdata[2:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; sclk_r <= 1'b0;
      bitcnt <= '0; shreg <= '0; rx_bit <= 1'b0;
    end else if (start) begin
      busy <= 1'b1; cnt <= '0; sclk_r <= 1'b0;
      bitcnt <= '0; shreg <= tx_hold;
    end else if (done) begin
      busy <= 1'b0; cnt <= '0; sclk_r <= 1'b0;
    end else if (busy) begin
      if (tick) begin
        cnt    <= '0;
        sclk_r <= ~sclk_r;
        if (rise) rx_bit <= miso;
        if (fall) begin
          shreg  <= rx_byte;
          bitcnt <= bitcnt + 3'd1;
        end
      end else begin
        cnt <= cnt + 8'd1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_hold <= '0; tx_full <= 1'b0;
    end else if (wr_tx) begin
      tx_hold <= wdata; tx_full <= 1'b1;
    end else if (start) begin
      tx_full <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_hold <= '0; rx_full <= 1'b0; ovr <= 1'b0;
    end else begin
      if (done && rx_full && !rd_rx)
        ovr <= 1'b1;
      else if (wr_en && addr == A_STAT && wdata[2])
        ovr <= 1'b0;
      if (done) begin
        if (!rx_full || rd_rx) begin
          rx_hold <= rx_byte; rx_full <= 1'b1;
        end
      end else if (rd_rx) begin
        rx_full <= 1'b0;
      end
    end

  always_comb
    case (addr)
      A_CTRL:  rdata = {7'd0, en_r};
      A_IE:    rdata = {5'd0, ie_r};
      A_DIV:   rdata = {5'd0, div_sel};
      A_STAT:  rdata = {4'd0, busy, ovr, rx_full, tx_full};
      A_RX:    rdata = rx_hold;
      default: rdata = 8'd0;
    endcase

  assign sclk = sclk_r;
  assign mosi = busy & shreg[7];
  assign ss_n = ~busy;
  assign irq  = (ie_r[0] & ~tx_full) | (ie_r[1] & rx_full) | (ie_r[2] & ovr);

  AST_IDLE_CLK_LOW:  assert property (@(posedge clk) disable iff (!rst_n) ss_n |-> !sclk); // R5
  AST_MOSI_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) sclk |-> $stable(mosi)); // R5
  AST_TX_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n) wr_tx |=> tx_full); // R3
  AST_RX_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (rd_rx && !done) |=> !rx_full); // R7
  AST_OVR_KEEP:      assert property (@(posedge clk) disable iff (!rst_n) (done && rx_full && !rd_rx) |=> (ovr && $stable(rx_hold))); // R8
  AST_IRQ_MASKED:    assert property (@(posedge clk) disable iff (!rst_n) (ie_r == 3'b000) |-> !irq); // R9
  AST_NO_GAP:        assert property (@(posedge clk) disable iff (!rst_n) (done && tx_full && en_r) |=> (!ss_n && !sclk)); // R11
  AST_HELD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!en_r && ss_n) |=> ss_n); // R10
endmodule

// File: tb/spi_master_dbuf_tb_top.sv
`timescale 1ns/1ps
module spi_master_dbuf_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rdata;
  logic sclk, mosi, ss_n, irq, miso;
  logic [7:0] sl = 8'h00;
  assign miso = sl[7];

  spi_master_dbuf dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n), .irq(irq));

  always #5 clk = ~clk;

  int total = 0, fails = 0, cyc = 0;
  bit finished = 0;

  int m_en, m_ie, m_sel, m_txf, m_txb, m_rxf, m_rxb, m_ovr, m_busy, m_p, m_sh, m_in;

  function automatic int ratio(int s);
    if (s == 0) return 1;
    if (s >= 6) return 128;
    return 2 << s;
  endfunction

  function automatic int m_sclk();
    return m_busy ? (m_p / ratio(m_sel)) % 2 : 0;
  endfunction

  function automatic int m_mosi();
    return m_busy ? (m_sh >> (7 - m_p / (2 * ratio(m_sel)))) & 1 : 0;
  endfunction

  function automatic int m_irq();
    return ((m_ie & 1) && !m_txf) || ((m_ie & 2) && m_rxf) || ((m_ie & 4) && m_ovr);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_en = 0; m_ie = 0; m_sel = 0; m_txf = 0; m_txb = 0; m_rxf = 0;
      m_rxb = 0; m_ovr = 0; m_busy = 0; m_p = 0; m_sh = 0; m_in = 0;
    end else begin
      int h, np, fin, go, rdrx;
      h = ratio(m_sel);
      fin = 0; np = m_p + 1;
      rdrx = rd_en && addr == 8'hD5;
      if (m_busy) begin
        if (np % (2 * h) == h) m_in = ((m_in << 1) | miso) & 255;
        if (np == 16 * h) fin = 1;
      end
      go = (!m_busy || fin) && m_en && m_txf;
      if (fin) begin
        if (m_rxf && !rdrx) m_ovr = 1;
        else begin m_rxb = m_in; m_rxf = 1; end
      end else if (rdrx) m_rxf = 0;
      if (wr_en && addr == 8'hD3 && wdata[2] && !(fin && m_ovr && m_rxf && !rdrx && 0)) begin
        if (!(fin && m_rxf && !rdrx)) m_ovr = 0;
      end
      if (go) begin m_busy = 1; m_p = 0; m_sh = m_txb; m_in = 0; end
      else if (fin) m_busy = 0;
      else if (m_busy) m_p = np;
      if (wr_en && addr == 8'hD4) begin m_txf = 1; m_txb = wdata; end
      else if (go) m_txf = 0;
      if (wr_en && addr == 8'hD0) m_en = wdata[0];
      if (wr_en && addr == 8'hD1) m_ie = wdata[2:0];
      if (wr_en && addr == 8'hD2) m_sel = wdata[2:0];
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (rst_n && !finished) begin
      check(sclk == m_sclk(), "R4 sclk", sclk, m_sclk());
      check(mosi == m_mosi(), "R5 mosi", mosi, m_mosi());
      check(ss_n == !m_busy, "R6 ss_n", ss_n, !m_busy);
      check(irq == m_irq(), "R9 irq", irq, m_irq());
    end
  end

  logic prev_sclk = 1'b0, prev_ss = 1'b1;
  logic [7:0] cap = 8'h00;
  int last_rise = 0, rise_gap = 0, ss_rises = 0;
  always @(negedge clk) begin
    if (sclk && !prev_sclk) begin
      cap = {cap[6:0], mosi};
      rise_gap = cyc - last_rise;
      last_rise = cyc;
    end
    if (!sclk && prev_sclk) sl = {sl[6:0], sl[7]};
    if (ss_n && !prev_ss) ss_rises++;
    prev_sclk = sclk;
    prev_ss = ss_n;
  end

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; addr = 8'h00;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 check(rdata == exp, tag, rdata, exp);
    @(negedge clk); rd_en = 1'b0; addr = 8'h00;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (!ss_n) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    total++; fails++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ss_n == 1 && sclk == 0 && mosi == 0 && irq == 0, "R1 reset pins", {ss_n, sclk, mosi, irq}, 4'b1000);
    rst_n = 1'b1;
    rd_chk(8'hD3, 8'h00, "R1 reset status");

    // single byte, fastest divider
    wr_reg(8'hD2, 8'd0); wr_reg(8'hD0, 8'h01);
    sl = 8'h3C;
    wr_reg(8'hD4, 8'hA5);
    wait_idle();
    check(cap == 8'hA5, "R5 msb-first byte out", cap, 8'hA5);
    check(rise_gap == 2, "R4 sel0 period", rise_gap, 2);
    rd_chk(8'hD3, 8'h02, "R7 rx full after byte");
    rd_chk(8'hD5, 8'h3C, "R7 received byte");
    rd_chk(8'hD3, 8'h00, "R7 read clears rx full");

    // R2 address behaviour
    wr_reg(8'hD5, 8'hEE);
    rd_chk(8'hD5, 8'h3C, "R2 rx write ignored");
    rd_chk(8'hD4, 8'h00, "R2 tx reads zero");

    // back-to-back, divider 4
    wr_reg(8'hD2, 8'd1);
    sl = 8'h96;
    ss_rises = 0;
    wr_reg(8'hD4, 8'h5A);
    wr_reg(8'hD4, 8'hC3);
    rd_chk(8'hD3, 8'h09, "R3 second byte queued while busy");
    repeat (66) @(negedge clk);
    rd_chk(8'hD5, 8'h96, "R7 first of burst");
    wait_idle();
    check(ss_rises == 1, "R6 R11 select held across burst", ss_rises, 1);
    check(cap == 8'hC3, "R11 second byte out", cap, 8'hC3);
    check(rise_gap == 8, "R4 sel1 period", rise_gap, 8);
    rd_chk(8'hD3, 8'h02, "R3 tx empty after burst");
    rd_chk(8'hD5, 8'h96, "R7 second of burst");

    // overrun
    wr_reg(8'hD2, 8'd0);
    sl = 8'h11; wr_reg(8'hD4, 8'h01); wait_idle();
    sl = 8'h22; wr_reg(8'hD4, 8'h02); wait_idle();
    rd_chk(8'hD3, 8'h06, "R8 overrun flagged");
    rd_chk(8'hD5, 8'h11, "R8 old byte kept");
    wr_reg(8'hD3, 8'h04);
    rd_chk(8'hD3, 8'h00, "R8 overrun cleared");

    // interrupts
    wr_reg(8'hD1, 8'h01); @(negedge clk);
    check(irq == 1, "R9 tx-empty irq", irq, 1);
    wr_reg(8'hD1, 8'h02); @(negedge clk);
    check(irq == 0, "R9 rx irq masked when empty", irq, 0);
    sl = 8'h44; wr_reg(8'hD4, 8'h55); wait_idle();
    check(irq == 1, "R9 rx-full irq", irq, 1);
    rd_chk(8'hD5, 8'h44, "R7 rx for irq");
    @(negedge clk);
    check(irq == 0, "R9 irq drops after read", irq, 0);
    wr_reg(8'hD1, 8'h00);

    // disabled controller holds queued byte
    wr_reg(8'hD0, 8'h00);
    sl = 8'h7E; wr_reg(8'hD4, 8'h77);
    repeat (40) @(negedge clk);
    check(ss_n == 1, "R10 no start while disabled", ss_n, 1);
    rd_chk(8'hD3, 8'h01, "R10 byte waits");
    wr_reg(8'hD0, 8'h01); wait_idle();
    rd_chk(8'hD5, 8'h7E, "R10 starts after enable");
    check(cap == 8'h77, "R10 held byte sent", cap, 8'h77);

    // slowest ratio, select 7 equals 6
    wr_reg(8'hD2, 8'd7);
    sl = 8'hB1; wr_reg(8'hD4, 8'h9D); wait_idle();
    check(rise_gap == 256, "R4 sel7 period", rise_gap, 256);
    rd_chk(8'hD5, 8'hB1, "R4 sel7 byte");
    wr_reg(8'hD2, 8'd3);
    sl = 8'h0F; wr_reg(8'hD4, 8'hF0); wait_idle();
    check(rise_gap == 32, "R4 sel3 period", rise_gap, 32);
    rd_chk(8'hD5, 8'h0F, "R4 sel3 byte");

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule